// File: doc/BRIEF.md
# Flash timing clock divider

This block turns a fast oscillator clock into a slow timing strobe for a nonvolatile-memory controller. Software writes one configuration register. That register holds a 6-bit divide field and a divide-by-8 prescale enable. While the block is running, it produces a single-cycle enable pulse on `tick` once every (field+1) × (8 when prescale is on, else 1) oscillator cycles. The memory controller's timing logic advances only on this pulse.

A sticky `loaded` flag records whether the register has been written since reset. Software cannot clear it; only reset returns it to 0. Command launches are gated by this flag. A launch made before the divider has been configured is dropped and raises a sticky access-error flag. A launch made when the divider is configured and no error is pending is forwarded on `cmd_valid`. Everything runs in the oscillator clock domain.

Top module: `ftclk_div`

## Requirements
- R1: After reset, `loaded`, `acc_err`, `cmd_valid` and `tick` are 0 and `cfg_rdata` reads 0.
- R2: A cycle with `cfg_wr`=1 stores `cfg_wdata`, with bit 6 as the prescale enable and bits 5:0 as the divide field. The stored value appears on `cfg_rdata` in the next cycle.
- R3: Any register write sets `loaded` in the next cycle, whatever data is written. `loaded` then stays 1 until reset. No write data and no `err_clr` clears it.
- R4: While `loaded` is 0, `tick` stays 0.
- R5: With prescale off, `tick` pulses once every field+1 cycles. With field 0 it is high every cycle.
- R6: With prescale on, `tick` pulses once every 8×(field+1) cycles.
- R7: A register write restarts the divider from zero, so the first tick at the new rate comes in the Nth cycle after the write edge, where N is the new period. No tick at the old rate follows the write.
- R8: `cmd_launch` while `loaded` is 0 sets `acc_err` in the next cycle and produces no `cmd_valid`.
- R9: `cmd_launch` while `loaded` is 1 and `acc_err` is 0 gives `cmd_valid`=1 for exactly one cycle, in the next cycle.
- R10: `acc_err` is sticky. While it is set, launches give no `cmd_valid`. `err_clr`=1 clears it in the next cycle, unless a rejected launch occurs in the same cycle, in which case setting wins.
- R11: A launch in the same cycle as the first register write is rejected, because `loaded` is still 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 7 | Write data: bit 6 is the prescale enable, bits 5:0 are the divide field |
| err_clr | input | 1 | Write-1-to-clear for the access error |
| cmd_launch | input | 1 | Command launch request |
| cfg_rdata | output | 7 | Current register contents |
| loaded | output | 1 | Register written since reset |
| acc_err | output | 1 | Sticky access-error flag |
| cmd_valid | output | 1 | Accepted command, one cycle |
| tick | output | 1 | Divided timing enable pulse |

## Verification
The divider is tried with these settings:
- field 0 without prescale, which separates an every-cycle strobe from an off-by-one counter;
- fields 4 and 63 without prescale, which check the plus-one rule and the widest field;
- fields 0 and 10 with prescale, which show that the ×8 stage multiplies rather than adds.

A rewrite in the middle of a period tells a true restart apart from a counter that simply carries on against the new terminal value. The command gate is driven in three states: before configuration, with an error pending, and with no error pending. It is also driven in the same-cycle cases of write-with-launch and clear-with-launch, which expose any ordering mistake between the flags.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    parameter int DIV_W = 6;           // programmable divide field width
    parameter int PRE_W = 3;           // prescale counter width (divide by 2**PRE_W)
    localparam int CFG_W = DIV_W + 1;  // register width: prescale bit above the field

    typedef struct packed {
        logic             pre;
        logic [DIV_W-1:0] div;
    } cfg_t;

    function automatic int unsigned period_of(cfg_t c);
        return (int'(c.div) + 1) * (c.pre ? (1 << PRE_W) : 1);
    endfunction
endpackage

// File: rtl/fdiv_cfg_reg.sv
module fdiv_cfg_reg
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic             loaded
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            loaded <= 1'b0;
        end else if (wr) begin
            cfg    <= cfg_t'(wdata);
            loaded <= 1'b1;
        end
    end

    // R3
    loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        loaded |=> loaded);

    // R2
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cfg == cfg_t'($past(wdata))) && loaded);
endmodule

// File: rtl/fdiv_counter.sv
module fdiv_counter
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  cfg_t cfg,
    output logic tick
);
    logic             pre_tick;
    logic [DIV_W-1:0] mc;

    generate
        if (PRE_W > 0) begin : g_pre
            logic [PRE_W-1:0] pc;
            always_ff @(posedge clk) begin
                if (rst || restart || !run || !cfg.pre)
                    pc <= '0;
                else
                    pc <= pc + 1'b1;
            end
            assign pre_tick = cfg.pre ? (pc == {PRE_W{1'b1}}) : 1'b1;
        end else begin : g_nopre
            assign pre_tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            mc <= '0;
        else if (pre_tick)
            mc <= (mc == cfg.div) ? '0 : mc + 1'b1;
    end

    assign tick = run && pre_tick && (mc == cfg.div);

    // R5
    mc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mc <= cfg.div);

    // R6
    pre_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.pre && tick && !restart) |=> !tick);
endmodule

// File: rtl/fdiv_cmd_gate.sv
module fdiv_cmd_gate (
    input  logic clk,
    input  logic rst,
    input  logic loaded,
    input  logic launch,
    input  logic err_clr,
    output logic acc_err,
    output logic cmd_valid
);
    logic reject;
    assign reject = launch && !loaded;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_err   <= 1'b0;
            cmd_valid <= 1'b0;
        end else begin
            if (reject)
                acc_err <= 1'b1;
            else if (err_clr)
                acc_err <= 1'b0;
            cmd_valid <= launch && loaded && !acc_err;
        end
    end

    // R8
    reject_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && !loaded) |=> (acc_err && !cmd_valid));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_err && !err_clr) |=> acc_err);

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (launch && loaded && !acc_err) |=> cmd_valid);
endmodule

// File: rtl/ftclk_div.sv
module ftclk_div
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             err_clr,
    input  logic             cmd_launch,
    output logic [CFG_W-1:0] cfg_rdata,
    output logic             loaded,
    output logic             acc_err,
    output logic             cmd_valid,
    output logic             tick
);
    cfg_t cfg;

    fdiv_cfg_reg u_reg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
        .cfg(cfg), .loaded(loaded)
    );

    fdiv_counter u_cnt (
        .clk(clk), .rst(rst), .restart(cfg_wr), .run(loaded),
        .cfg(cfg), .tick(tick)
    );

    fdiv_cmd_gate u_gate (
        .clk(clk), .rst(rst), .loaded(loaded), .launch(cmd_launch),
        .err_clr(err_clr), .acc_err(acc_err), .cmd_valid(cmd_valid)
    );

    assign cfg_rdata = cfg;

    // R4
    idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!loaded && !cfg_wr) |=> !tick);
endmodule

// File: tb/ftclk_div_test.sv
module ftclk_div_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       err_clr = 1'b0;
    logic       cmd_launch = 1'b0;
    logic [6:0] cfg_rdata;
    logic       loaded, acc_err, cmd_valid, tick;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    ftclk_div uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .err_clr(err_clr), .cmd_launch(cmd_launch), .cfg_rdata(cfg_rdata),
        .loaded(loaded), .acc_err(acc_err), .cmd_valid(cmd_valid), .tick(tick)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cfg_wr = 0; err_clr = 0; cmd_launch = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // leaves the caller at the first negedge after the write edge
    task automatic write_cfg(bit pre, int div);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = {pre, 6'(div)};
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 loaded", loaded, 0);
        chk("R1 acc_err", acc_err, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 tick", tick, 0);
        chk("R1 cfg_rdata", cfg_rdata, 0);
    endtask

    task automatic t_no_tick_unloaded();
        int seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tick) seen++;
        end
        chk("R4 ticks before load", seen, 0);
    endtask

    task automatic t_reject_unloaded();
        @(negedge clk);
        cmd_launch = 1'b1;
        @(negedge clk);
        cmd_launch = 1'b0;
        chk("R8 acc_err set", acc_err, 1);
        chk("R8 no cmd_valid", cmd_valid, 0);
    endtask

    task automatic t_load_and_gate();
        write_cfg(1'b0, 4);
        chk("R2 cfg_rdata", cfg_rdata, 7'h04);
        chk("R3 loaded set", loaded, 1);
        cmd_launch = 1'b1;
        @(negedge clk);
        cmd_launch = 1'b0;
        chk("R10 blocked while err", cmd_valid, 0);
        chk("R10 err sticky", acc_err, 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R10 err cleared", acc_err, 0);
        chk("R3 loaded after err_clr", loaded, 1);
        cmd_launch = 1'b1;
        @(negedge clk);
        cmd_launch = 1'b0;
        chk("R9 cmd_valid", cmd_valid, 1);
        chk("R9 no error", acc_err, 0);
        @(negedge clk);
        chk("R9 single pulse", cmd_valid, 0);
    endtask

    // checks first tick at cycle N after write and spacing N to the next tick
    task automatic t_period(string tag, bit pre, int div);
        int n = (div + 1) * (pre ? 8 : 1);
        int k1 = -1;
        int k2 = -1;
        write_cfg(pre, div);
        chk({tag, " cfg_rdata"}, cfg_rdata, {pre, 6'(div)});
        for (int k = 1; k <= 2 * n + 2; k++) begin
            if (tick) begin
                if (k1 < 0) k1 = k;
                else if (k2 < 0) k2 = k;
            end
            @(negedge clk);
        end
        chk({tag, " first tick"}, k1, n);
        chk({tag, " period"}, k2 - k1, n);
    endtask

    task automatic t_restart();
        int k1 = -1;
        write_cfg(1'b0, 9);
        for (int i = 0; i < 3; i++) @(negedge clk);
        write_cfg(1'b0, 2);
        for (int k = 1; k <= 12; k++) begin
            if (tick && k1 < 0) k1 = k;
            @(negedge clk);
        end
        chk("R7 restart first tick", k1, 3);
    endtask

    task automatic t_zero_write_keeps_loaded();
        write_cfg(1'b0, 0);
        chk("R3 loaded after zero write", loaded, 1);
        chk("R2 cfg_rdata zero", cfg_rdata, 0);
    endtask

    task automatic t_same_cycle_write_launch();
        do_reset();
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = 7'h03; cmd_launch = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; cmd_launch = 1'b0;
        chk("R11 acc_err", acc_err, 1);
        chk("R11 no cmd_valid", cmd_valid, 0);
        chk("R11 loaded", loaded, 1);
    endtask

    task automatic t_set_beats_clear();
        do_reset();
        @(negedge clk);
        cmd_launch = 1'b1; err_clr = 1'b1;
        @(negedge clk);
        cmd_launch = 1'b0; err_clr = 1'b0;
        chk("R10 set wins over clear", acc_err, 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_no_tick_unloaded();
        t_reject_unloaded();
        t_load_and_gate();
        t_period("R5 div4", 1'b0, 4);
        t_period("R5 div0", 1'b0, 0);
        t_period("R5 div63", 1'b0, 63);
        t_period("R6 pre div10", 1'b1, 10);
        t_period("R6 pre div0", 1'b1, 0);
        t_restart();
        t_zero_write_keeps_loaded();
        t_same_cycle_write_launch();
        t_set_beats_clear();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule